// File: doc/BRIEF.md
# Random Sample Register Controller

This block puts a small bank of 32-bit registers in front of a random-bit source and controls when that source may be read. Software first programs three sample counts and a clock divider. The counts are a warm-up length, a lower bound on the refill length and an upper bound on the refill length. Software then sets a run bit. The block takes one sample every divider-plus-one clock cycles and counts those samples. When the count is reached, it raises a ready flag and captures a 64-bit value, which software reads as two 32-bit words.

Software reads the low word first and then the high word, and then writes an acknowledge. The acknowledge clears the ready flag and starts a refill period. Ready comes back only after that period has run. A 64-bit linear feedback shift register, advanced once per sample, stands in for the noise source. The sample-count fields use a scaled encoding in which a zero field selects the full count `FULL_SAMPLES` (2^24 by default; a bench may set it lower).

Top module: `trng_refill_ctrl`

## Requirements
- R1: After reset the ready flag, the interrupt output, the control word, the mask word and both result words read as zero.
- R2: Word offsets are 0 result low, 1 result high, 2 status, 3 mask, 4 acknowledge, 5 control, 6 config. Control holds the run bit at bit 10 and the warm-up field at [23:16]. Config holds the minimum refill field at [7:0], the divider at [15:8] and the maximum refill field at [23:16]. Mask holds its enable at bit 0. All of these read back as written.
- R3: After the run bit goes from 0 to 1, ready rises once the warm-up count of samples has elapsed. A warm-up field F gives F×256 samples, and F=0 gives FULL_SAMPLES.
- R4: While running, one sample is taken every (divider+1) clock cycles, so every sample count stretches by that factor.
- R5: Writing 1 to bit 0 of the acknowledge word while ready clears ready and starts a refill. Ready returns after max(min×64, max×256) samples, where a zero field counts as FULL_SAMPLES.
- R6: An acknowledge write with bit 0 clear has no effect, and neither does an acknowledge while not ready. Neither one changes the state or the timing.
- R7: Both result words are captured when ready rises and stay stable until the acknowledge. Writes to offsets 0 and 1 do not change them, and each refill yields a new, nonzero value.
- R8: The interrupt output equals ready AND mask bit 0.
- R9: Writing control with bit 10 clear stops the block. Ready and the interrupt drop, and no new ready appears.
- R10: Status bit 0 is the ready flag, and status bits [31:1] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 3 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, ready gated by mask |

## Verification
The hardest condition to reach from the ports is an acknowledge that arrives during warm-up, while ready is still low. That acknowledge must leave the sample count undisturbed. The stimulus starts a warm-up, writes the acknowledge partway through, and keeps counting cycles across the write to check that ready arrives at exactly the same cycle as an undisturbed run. The bench also covers the refill case where the minimum bound exceeds the maximum bound and the cases where zero fields select the full count. It measures each of these periods cycle-exactly with a reduced FULL_SAMPLES.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int FIELD_W  = 8;
  localparam int RES_W    = 64;

  localparam int RUN_BIT    = 10;
  localparam int WARM_LSB   = 16;
  localparam int MINF_LSB   = 0;
  localparam int DIV_LSB    = 8;
  localparam int MAXF_LSB   = 16;

  localparam int WARM_SHIFT = 8;
  localparam int MINF_SHIFT = 6;
  localparam int MAXF_SHIFT = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_RES_LO = 3'd0,
    OFS_RES_HI = 3'd1,
    OFS_STAT   = 3'd2,
    OFS_MASK   = 3'd3,
    OFS_ACK    = 3'd4,
    OFS_CTRL   = 3'd5,
    OFS_CFG    = 3'd6
  } reg_ofs_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WARM = 2'd1,
    PH_FILL = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;
endpackage

// File: rtl/trng_tick_div.sv
module trng_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt_q <= '0;
    else if (tick)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && !restart && $stable(div)) |=> !tick);
endmodule

// File: rtl/trng_lfsr64.sv
module trng_lfsr64 #(
  parameter int              W    = 64,
  parameter logic [W-1:0]    TAPS = 64'hD800_0000_0000_0000,
  parameter logic [W-1:0]    SEED = 64'h1234_5678_9ABC_DEF1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= (state >> 1) ^ (state[0] ? TAPS : '0);
  end

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/trng_sample_ctr.sv
module trng_sample_ctr #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign done    = en && (cnt_inc >= target);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (en)      cnt_q <= done ? '0 : cnt_inc;
  end

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/trng_refill_ctrl.sv
module trng_refill_ctrl
  import trng_pkg::*;
#(
  parameter int FULL_SAMPLES = 1 << 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int FIELD_MAX = ((1 << FIELD_W) - 1) << 8;
  localparam int MAX_CNT   = (FULL_SAMPLES > FIELD_MAX) ? FULL_SAMPLES : FIELD_MAX;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL_SAMPLES);

  logic               run_q;
  logic [FIELD_W-1:0] warm_f_q, minf_q, div_q, maxf_q;
  logic               mask_q;
  phase_e             phase_q, phase_d;
  logic [RES_W-1:0]   res_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               ready;

  logic wr_ctrl, wr_cfg, wr_mask, ack_hit, go, restart;
  logic tick, cnt_en, done;
  logic [RES_W-1:0] lfsr;
  logic [CNT_W-1:0] warm_cnt, min_cnt, max_cnt, fill_cnt, target;

  assign ready   = (phase_q == PH_HOLD);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_cfg  = reg_wr && (reg_addr == OFS_CFG);
  assign wr_mask = reg_wr && (reg_addr == OFS_MASK);
  assign ack_hit = reg_wr && (reg_addr == OFS_ACK) && reg_wdata[0] && ready;
  assign go      = wr_ctrl && reg_wdata[RUN_BIT] && (phase_q == PH_IDLE);
  assign restart = go || ack_hit;

  // scaled sample counts: zero field selects the full count
  assign warm_cnt = (warm_f_q == '0) ? FULL_C : (CNT_W'(warm_f_q) << WARM_SHIFT);
  assign min_cnt  = (minf_q   == '0) ? FULL_C : (CNT_W'(minf_q)   << MINF_SHIFT);
  assign max_cnt  = (maxf_q   == '0) ? FULL_C : (CNT_W'(maxf_q)   << MAXF_SHIFT);
  assign fill_cnt = (min_cnt > max_cnt) ? min_cnt : max_cnt;
  assign target   = (phase_q == PH_WARM) ? warm_cnt : fill_cnt;
  assign cnt_en   = tick && ((phase_q == PH_WARM) || (phase_q == PH_FILL));

  trng_tick_div #(.DIV_W(FIELD_W)) u_div (
    .clk(clk), .rst(rst), .run(run_q), .restart(restart),
    .div(div_q), .tick(tick)
  );

  trng_lfsr64 #(.W(RES_W)) u_src (
    .clk(clk), .rst(rst), .step(tick), .state(lfsr)
  );

  trng_sample_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(restart), .en(cnt_en),
    .target(target), .done(done)
  );

  always_comb begin
    phase_d = phase_q;
    if (wr_ctrl && !reg_wdata[RUN_BIT]) phase_d = PH_IDLE;
    else if (go)                        phase_d = PH_WARM;
    else if (ack_hit)                   phase_d = PH_FILL;
    else if (done)                      phase_d = PH_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      warm_f_q <= '0;
      minf_q   <= '0;
      div_q    <= '0;
      maxf_q   <= '0;
      mask_q   <= 1'b0;
      phase_q  <= PH_IDLE;
      res_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (wr_ctrl) begin
        run_q    <= reg_wdata[RUN_BIT];
        warm_f_q <= reg_wdata[WARM_LSB +: FIELD_W];
      end
      if (wr_cfg) begin
        minf_q <= reg_wdata[MINF_LSB +: FIELD_W];
        div_q  <= reg_wdata[DIV_LSB  +: FIELD_W];
        maxf_q <= reg_wdata[MAXF_LSB +: FIELD_W];
      end
      if (wr_mask) mask_q <= reg_wdata[0];
      if (phase_d == PH_HOLD && phase_q != PH_HOLD) res_q <= lfsr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) begin
      rdata_q <= '0;
      case (reg_addr)
        OFS_RES_LO: rdata_q <= res_q[DATA_W-1:0];
        OFS_RES_HI: rdata_q <= res_q[RES_W-1:DATA_W];
        OFS_STAT:   rdata_q[0] <= ready;
        OFS_MASK:   rdata_q[0] <= mask_q;
        OFS_CTRL: begin
          rdata_q[RUN_BIT] <= run_q;
          rdata_q[WARM_LSB +: FIELD_W] <= warm_f_q;
        end
        OFS_CFG: begin
          rdata_q[MINF_LSB +: FIELD_W] <= minf_q;
          rdata_q[DIV_LSB  +: FIELD_W] <= div_q;
          rdata_q[MAXF_LSB +: FIELD_W] <= maxf_q;
        end
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = ready && mask_q;

  // R7
  res_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> $stable(res_q));
  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !reg_wdata[RUN_BIT]) |=> !irq);
  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_ACK && reg_wdata[0] && ready) |=> !ready);
  // R3
  ready_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> run_q);
  // R10
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && reg_addr == OFS_STAT) |-> (reg_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/test_trng_refill_ctrl.sv
module test_trng_refill_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FULL       = 1000;
  localparam int NVEC       = 4;
  localparam int WAIT_CAP   = 4000;

  // {warm field, div, min field, max field, startup cycles, refill cycles}
  localparam int VEC [NVEC][6] = '{
    '{1, 0, 1, 1,  256,  256},
    '{2, 1, 8, 1, 1024, 1024},
    '{0, 0, 0, 2, 1000, 1000},
    '{1, 2, 2, 0,  768, 3000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  trng_refill_ctrl #(.FULL_SAMPLES(FULL)) i_trng_refill_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // counts edges after the last write until irq is seen high
  task automatic wait_irq(output int n);
    n = 0;
    while (n < WAIT_CAP) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (irq) break;
    end
  endtask

  initial begin
    logic [31:0] d, lo, hi, lo2, hi2;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(3'd2, d); check("R1 status", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(3'd5, d); check("R1 ctrl", d, 0);
    rd(3'd3, d); check("R1 mask", d, 0);
    rd(3'd0, d); check("R1 res lo", d, 0);
    rd(3'd1, d); check("R1 res hi", d, 0);

    // R2 readback
    wr(3'd6, 32'h00AB_CD12); rd(3'd6, d); check("R2 cfg", d, 32'h00AB_CD12);
    wr(3'd3, 32'h1);         rd(3'd3, d); check("R2 mask", d, 32'h1);
    wr(3'd5, 32'h0037_0000); rd(3'd5, d); check("R2 ctrl", d, 32'h0037_0000);

    // table: R3 startup, R4 divider, R5 refill, R7 results
    for (int v = 0; v < NVEC; v++) begin
      wr(3'd5, 32'h0);
      wr(3'd6, (VEC[v][3] << 16) | (VEC[v][1] << 8) | VEC[v][2]);
      wr(3'd3, 32'h1);
      wr(3'd5, (VEC[v][0] << 16) | (1 << 10));
      wait_irq(n);
      check("R3 R4 startup cycles", n, VEC[v][4]);
      rd(3'd2, d); check("R10 status ready", d, 32'h1);
      rd(3'd0, lo); rd(3'd1, hi);
      checks++;
      if (lo == 0 && hi == 0) begin
        errors++;
        $display("FAIL R7: actual 0 expected nonzero result");
      end
      wr(3'd4, 32'h1);
      check("R5 ack clears", {31'd0, irq}, 0);
      wait_irq(n);
      check("R5 R4 refill cycles", n, VEC[v][5]);
      rd(3'd0, lo2); rd(3'd1, hi2);
      checks++;
      if ({hi2, lo2} == {hi, lo}) begin
        errors++;
        $display("FAIL R7: actual %h repeated expected new value", {hi2, lo2});
      end
    end

    // R6 ack during warm-up leaves timing unchanged
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h0001_0001);
    wr(3'd5, 32'h0001_0400);
    n = 0;
    while (n < WAIT_CAP) begin
      if (n == 49) begin reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1; end
      else reg_wr = 1'b0;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (irq) break;
    end
    reg_wr = 1'b0;
    check("R6 ack while not ready", n, 256);
    wr(3'd4, 32'h0);
    rd(3'd2, d); check("R6 ack bit0 clear", d, 32'h1);

    // R7 stability and write immunity
    rd(3'd0, lo); repeat (20) @(posedge clk); rd(3'd0, lo2);
    check("R7 stable lo", lo2, lo);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, lo2); check("R7 write ignored lo", lo2, lo);
    rd(3'd1, hi); wr(3'd1, 32'h0); rd(3'd1, hi2); check("R7 write ignored hi", hi2, hi);

    // R8 mask gating
    wr(3'd3, 32'h0);
    check("R8 irq masked", {31'd0, irq}, 0);
    rd(3'd2, d); check("R8 status still ready", d, 32'h1);
    wr(3'd3, 32'h1);
    check("R8 irq unmasked", {31'd0, irq}, 1);

    // R9 stop
    wr(3'd5, 32'h0001_0000);
    check("R9 irq after stop", {31'd0, irq}, 0);
    rd(3'd2, d); check("R9 status after stop", d, 0);
    repeat (600) @(posedge clk);
    rd(3'd2, d); check("R9 no ready while stopped", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule